// File: doc/BRIEF.md
# Cached Page-Program Status Tracker

This block follows the two-stage pipeline behind cached page programming in a flash array controller: a cache register that receives the host's next page, and a data register whose contents are being written into the cells. It does not hold the page data. It receives single-cycle decoded events and tracks when each stage is occupied. The events are a cache-confirm command, a final-confirm command, a pulse from the transfer timer saying the cache-to-data copy is finished, and a pulse from the program timer, with a pass/fail flag, saying cell programming is finished.

From those events the block produces a status byte and a ready/busy line. The status byte has four live bits. One says the cache can accept a new page. A separate one says the array has nothing in flight. The other two hold the pass/fail result of the page now in the array and of the page before it. A confirm is only taken while the cache is free. A confirm that arrives while the cache is occupied is dropped, and a one-cycle protocol-error pulse is raised so a testbench can see it.

All outputs are registered. An event sampled on clock edge k shows on the outputs right after edge k.

Top module: `cp_status_tracker`

## Requirements
- R1: Asynchronous reset gives status 0x60 (bit 6 cache-free = 1, bit 5 array-idle = 1, every other bit 0), `ready_o` = 1 and `proto_err_o` = 0.
- R2: A cache-confirm accepted while the array is idle starts the transfer at once. Bit 6 and `ready_o` drop to 0 on the next cycle. When the transfer-done pulse arrives they return to 1 and the array becomes busy.
- R3: A cache-confirm accepted while the array is programming waits, and bit 6 stays 0. The transfer starts on the edge where the program-done pulse is accepted, including when that pulse arrives in the same cycle as the confirm.
- R4: Bit 5 is 0 while a transfer or cell programming is in progress. It becomes 1 only when a program-done pulse is accepted and no new transfer starts in that same cycle.
- R5: When a program-done pulse is accepted, bit 0 takes the pass/fail flag (1 = fail, 0 = pass).
- R6: When a transfer completes, bit 1 takes the previous value of bit 0, and bit 0 is cleared for the new page.
- R7: After an accepted final-confirm, bit 6 and `ready_o` stay 0 through the transfer and stay 0 until that page's program-done pulse is accepted.
- R8: A cache-confirm or final-confirm that arrives while bit 6 is 0 changes nothing. `proto_err_o` is 1 for exactly the following cycle.
- R9: A transfer-done pulse with no transfer in progress, or a program-done pulse while the array is not programming, has no effect on any output.
- R10: `ready_o` always equals status bit 6. Status bits 7, 4, 3 and 2 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cache_cmd_i | input | 1 | Decoded cache-confirm command pulse |
| final_cmd_i | input | 1 | Decoded final-confirm command pulse (wins if both commands are high) |
| xfer_done_i | input | 1 | Cache-to-data transfer finished pulse |
| prog_done_i | input | 1 | Cell programming finished pulse |
| prog_fail_i | input | 1 | Fail flag, qualified by prog_done_i |
| status_o | output | 8 | Status byte |
| ready_o | output | 1 | Ready (1) / busy (0) |
| proto_err_o | output | 1 | One-cycle pulse for a rejected command |

## Verification
On every cycle, the assertions check that a confirm taken while the cache is free makes the block busy, and that a confirm refused while busy produces the error pulse. They also check that array-idle only rises after a program-done, that the previous-page bit only moves on a transfer-done, and that a fail bit only appears on a failing program-done. Some behaviours need a full scenario and cannot be seen from one clock: the confirm that waits behind a busy array, the hold of busy after a final-confirm, the history shift across several pages, and stray pulses that must be ignored. The bench's reference model and its directed sequences cover these.

// File: rtl/cp_pkg.sv
package cp_pkg;
  localparam int STAT_W         = 8;
  localparam int HIST_DEPTH     = 2;
  localparam int BIT_CUR        = 0;
  localparam int BIT_ARR_IDLE   = 5;
  localparam int BIT_CACHE_FREE = 6;

  typedef struct packed {
    logic accept;
    logic final_pg;
    logic reject;
  } cp_cmd_t;
endpackage

// File: rtl/cp_cmd_qual.sv
module cp_cmd_qual
  import cp_pkg::*;
(
  input  logic    cache_cmd_i,
  input  logic    final_cmd_i,
  input  logic    cache_busy_i,
  output cp_cmd_t cmd_o
);
  logic any_cmd;

  always_comb begin
    any_cmd        = cache_cmd_i | final_cmd_i;
    cmd_o.accept   = any_cmd & ~cache_busy_i;
    cmd_o.reject   = any_cmd & cache_busy_i;
    cmd_o.final_pg = final_cmd_i;
  end
endmodule

// File: rtl/cp_pipe_ctrl.sv
module cp_pipe_ctrl
  import cp_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  cp_cmd_t cmd_i,
  input  logic    xfer_done_i,
  input  logic    prog_done_i,
  output logic    cache_busy_o,
  output logic    array_busy_o,
  output logic    xfer_busy_o,
  output logic    load_new_o,
  output logic    capture_o,
  output logic    proto_err_o
);
  logic cache_busy_q, cache_busy_n;
  logic array_busy_q, array_busy_n;
  logic xfer_q, xfer_n;
  logic wait_q, wait_n;
  logic fin_cache_q, fin_cache_n;
  logic fin_arr_q, fin_arr_n;
  logic err_q, err_n;
  logic capture, load_new;

  always_comb begin
    capture      = prog_done_i & array_busy_q;
    load_new     = xfer_done_i & xfer_q;
    cache_busy_n = cache_busy_q;
    array_busy_n = array_busy_q;
    xfer_n       = xfer_q;
    wait_n       = wait_q;
    fin_cache_n  = fin_cache_q;
    fin_arr_n    = fin_arr_q;
    err_n        = cmd_i.reject;

    if (capture) begin
      array_busy_n = 1'b0;
      if (fin_arr_q) begin
        fin_arr_n    = 1'b0;
        cache_busy_n = 1'b0;
      end
    end

    if (load_new) begin
      xfer_n       = 1'b0;
      array_busy_n = 1'b1;
      fin_arr_n    = fin_cache_q;
      if (!fin_cache_q) cache_busy_n = 1'b0;
    end

    if (cmd_i.accept) begin
      cache_busy_n = 1'b1;
      fin_cache_n  = cmd_i.final_pg;
      wait_n       = 1'b1;
    end

    if (wait_n && !array_busy_n && !xfer_n) begin
      xfer_n = 1'b1;
      wait_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cache_busy_q <= 1'b0;
      array_busy_q <= 1'b0;
      xfer_q       <= 1'b0;
      wait_q       <= 1'b0;
      fin_cache_q  <= 1'b0;
      fin_arr_q    <= 1'b0;
      err_q        <= 1'b0;
    end else begin
      cache_busy_q <= cache_busy_n;
      array_busy_q <= array_busy_n;
      xfer_q       <= xfer_n;
      wait_q       <= wait_n;
      fin_cache_q  <= fin_cache_n;
      fin_arr_q    <= fin_arr_n;
      err_q        <= err_n;
    end
  end

  assign cache_busy_o = cache_busy_q;
  assign array_busy_o = array_busy_q;
  assign xfer_busy_o  = xfer_q;
  assign load_new_o   = load_new;
  assign capture_o    = capture;
  assign proto_err_o  = err_q;
endmodule

// File: rtl/cp_result_hist.sv
module cp_result_hist #(
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_new_i,
  input  logic             capture_i,
  input  logic             fail_i,
  output logic [DEPTH-1:0] res_o
);
  logic [DEPTH-1:0] res_q, res_n;

  always_comb begin
    res_n = res_q;
    if (capture_i) res_n[0] = fail_i;
    else if (load_new_i) res_n[0] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) res_q[0] <= 1'b0;
    else        res_q[0] <= res_n[0];
  end

  for (genvar g = 1; g < DEPTH; g++) begin : g_hist
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          res_q[g] <= 1'b0;
      else if (load_new_i) res_q[g] <= res_q[g-1];
    end
  end

  assign res_o = res_q;
endmodule

// File: rtl/cp_status_tracker.sv
module cp_status_tracker
  import cp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cache_cmd_i,
  input  logic              final_cmd_i,
  input  logic              xfer_done_i,
  input  logic              prog_done_i,
  input  logic              prog_fail_i,
  output logic [STAT_W-1:0] status_o,
  output logic              ready_o,
  output logic              proto_err_o
);
  cp_cmd_t         cmd;
  logic            cache_busy, array_busy, xfer_busy, load_new, capture;
  logic [HIST_DEPTH-1:0] res;

  cp_cmd_qual u_qual (
    .cache_cmd_i (cache_cmd_i),
    .final_cmd_i (final_cmd_i),
    .cache_busy_i(cache_busy),
    .cmd_o       (cmd)
  );

  cp_pipe_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_i       (cmd),
    .xfer_done_i (xfer_done_i),
    .prog_done_i (prog_done_i),
    .cache_busy_o(cache_busy),
    .array_busy_o(array_busy),
    .xfer_busy_o (xfer_busy),
    .load_new_o  (load_new),
    .capture_o   (capture),
    .proto_err_o (proto_err_o)
  );

  cp_result_hist #(.DEPTH(HIST_DEPTH)) u_hist (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_new_i(load_new),
    .capture_i (capture),
    .fail_i    (prog_fail_i),
    .res_o     (res)
  );

  always_comb begin
    status_o                          = '0;
    status_o[BIT_CUR +: HIST_DEPTH]   = res;
    status_o[BIT_ARR_IDLE]            = ~(array_busy | xfer_busy);
    status_o[BIT_CACHE_FREE]          = ~cache_busy;
  end

  assign ready_o = ~cache_busy;
endmodule

// File: rtl/cp_status_tracker_chk.sv
module cp_status_tracker_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cache_cmd_i,
  input logic       final_cmd_i,
  input logic       xfer_done_i,
  input logic       prog_done_i,
  input logic       prog_fail_i,
  input logic [7:0] status_o,
  input logic       ready_o,
  input logic       proto_err_o
);
  assert_accept_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((cache_cmd_i || final_cmd_i) && ready_o) |=> !ready_o);

  assert_reject_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((cache_cmd_i || final_cmd_i) && !ready_o) |=> proto_err_o);

  assert_err_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err_o |-> $past((cache_cmd_i || final_cmd_i) && !ready_o));

  assert_idle_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_o[5]) |-> $past(prog_done_i));

  assert_prev_moves_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(status_o[1]) |-> $past(xfer_done_i));

  assert_fail_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_o[0]) |-> $past(prog_done_i && prog_fail_i));

  always_comb begin
    if (rst_n) begin
      assert_ready_bit_R10: assert (ready_o == status_o[6]);
    end
  end
endmodule

bind cp_status_tracker cp_status_tracker_chk chk_i (.*);

// File: tb/cp_status_tracker_tb_top.sv
module cp_status_tracker_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cache_cmd_i, final_cmd_i, xfer_done_i, prog_done_i, prog_fail_i;
  logic [7:0] status_o;
  logic       ready_o, proto_err_o;

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;
  bit done    = 0;

  // behavioural reference state
  int  m_cache_full, m_cache_fin, m_waiting, m_xfer, m_arr, m_arr_fin;
  int  m_r0, m_r1, m_err;

  always #2.5 clk = ~clk;

  cp_status_tracker dut_i (.*);

  function automatic logic [7:0] model_status();
    logic [7:0] s;
    s    = 8'h00;
    s[0] = (m_r0 != 0);
    s[1] = (m_r1 != 0);
    s[5] = (m_arr == 0 && m_xfer == 0);
    s[6] = (m_cache_full == 0);
    return s;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cache_full = 0; m_cache_fin = 0; m_waiting = 0; m_xfer = 0;
      m_arr = 0; m_arr_fin = 0; m_r0 = 0; m_r1 = 0; m_err = 0;
    end else begin
      int o_full, o_xfer, o_arr;
      o_full = m_cache_full; o_xfer = m_xfer; o_arr = m_arr;
      m_err = 0;
      if (prog_done_i && o_arr != 0) begin
        m_arr = 0;
        m_r0  = prog_fail_i;
        if (m_arr_fin != 0) begin m_arr_fin = 0; m_cache_full = 0; end
      end
      if (xfer_done_i && o_xfer != 0) begin
        m_xfer = 0; m_arr = 1;
        m_r1 = m_r0; m_r0 = 0;
        m_arr_fin = m_cache_fin;
        if (m_cache_fin == 0) m_cache_full = 0;
      end
      if (cache_cmd_i || final_cmd_i) begin
        if (o_full != 0) m_err = 1;
        else begin
          m_cache_full = 1; m_cache_fin = final_cmd_i; m_waiting = 1;
        end
      end
      if (m_waiting != 0 && m_arr == 0 && m_xfer == 0) begin
        m_xfer = 1; m_waiting = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [7:0] e;
      e = model_status();
      vectors++;
      if (status_o[6] !== e[6] || ready_o !== e[6]) begin
        errors++; $display("FAIL R2 cache-free/ready: got %b/%b exp %b", status_o[6], ready_o, e[6]);
      end
      if (status_o[5] !== e[5]) begin
        errors++; $display("FAIL R4 array-idle: got %b exp %b", status_o[5], e[5]);
      end
      if (status_o[0] !== e[0]) begin
        errors++; $display("FAIL R5 current result: got %b exp %b", status_o[0], e[0]);
      end
      if (status_o[1] !== e[1]) begin
        errors++; $display("FAIL R6 previous result: got %b exp %b", status_o[1], e[1]);
      end
      if (proto_err_o !== (m_err != 0)) begin
        errors++; $display("FAIL R8 proto_err: got %b exp %0d", proto_err_o, m_err);
      end
      if ({status_o[7], status_o[4:2]} !== 4'b0000) begin
        errors++; $display("FAIL R10 reserved bits: got %b exp 0000", {status_o[7], status_o[4:2]});
      end
    end
  end

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic pulse(input logic c, input logic f, input logic x, input logic p, input logic pf);
    cache_cmd_i = c; final_cmd_i = f; xfer_done_i = x; prog_done_i = p; prog_fail_i = pf;
    @(negedge clk);
    cache_cmd_i = 0; final_cmd_i = 0; xfer_done_i = 0; prog_done_i = 0; prog_fail_i = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    cache_cmd_i = 0; final_cmd_i = 0; xfer_done_i = 0; prog_done_i = 0; prog_fail_i = 0;
    rst_n = 0;
    idle(3);
    check("R1 status", status_o, 8'h60);
    check("R1 ready/err", {6'd0, ready_o, proto_err_o}, 8'h02);
    rst_n = 1;
    idle(1);

    // R2: page into idle pipeline
    pulse(1,0,0,0,0);
    check("R2 busy after confirm", status_o, 8'h00);
    idle(2);
    pulse(0,0,1,0,0);
    check("R2 free after transfer", status_o, 8'h40);
    // R3: second page waits for array
    pulse(1,0,0,0,0);
    check("R3 waiting", status_o, 8'h00);
    idle(4);
    check("R3 still waiting", {7'd0, ready_o}, 8'h00);
    pulse(0,0,0,1,1);
    check("R5 fail captured, R3 transfer started", status_o, 8'h01);
    pulse(0,0,1,0,0);
    check("R6 shift on transfer", status_o, 8'h42);
    pulse(0,0,0,1,0);
    check("R4 array idle after pass", status_o, 8'h62);

    // R9: stray pulses while idle
    pulse(0,0,1,0,0);
    check("R9 stray transfer-done", status_o, 8'h62);
    pulse(0,0,0,1,1);
    check("R9 stray program-done", status_o, 8'h62);

    // R8: confirm while cache busy
    pulse(1,0,0,0,0);
    pulse(1,0,0,0,0);
    check("R8 error pulse", {7'd0, proto_err_o}, 8'h01);
    idle(1);
    check("R8 error clears", {7'd0, proto_err_o}, 8'h00);
    pulse(0,0,1,0,0);
    check("R6 history after third transfer", status_o, 8'h40);

    // R3: confirm coinciding with program-done
    pulse(1,0,0,1,1);
    check("R3 same-cycle start", status_o, 8'h01);
    pulse(0,0,1,0,0);
    check("R6 fail moves to previous", status_o, 8'h42);

    // R7: final confirm behind busy array
    pulse(0,1,0,0,0);
    check("R7 final waiting", status_o, 8'h02);
    pulse(0,0,0,1,0);
    pulse(0,0,1,0,0);
    check("R7 busy after final transfer", {7'd0, ready_o}, 8'h00);
    idle(3);
    check("R7 still busy", status_o, 8'h00);
    pulse(1,0,0,0,0);
    check("R8 rejected during final hold", {7'd0, proto_err_o}, 8'h01);
    pulse(0,0,0,1,1);
    check("R7 ready after last program", status_o, 8'h61);

    // R2: final confirm with both commands high into idle array
    pulse(1,1,0,0,0);
    pulse(0,0,1,0,0);
    pulse(0,0,0,1,0);
    check("R7 final from idle", status_o, 8'h62);
    idle(2);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule